// File: doc/BRIEF.md
# Two-Level Round-Robin Warp Fetch Scheduler

This block chooses, each clock cycle, at most one warp to receive an instruction fetch slot. The warps are split into equal fetch groups by consecutive ID. The groups are ranked in a rotating order, and warps in a higher-ranked group always win over warps in lower-ranked ones. Inside a group, the warps take turns.

The ranking moves on by one place in two cases. The first is when every warp of the top group is held by a long-latency stall. The second is when the top group has kept its rank for a programmable number of retired instructions. Either way the old top group drops to the bottom of the order. Because of this, only one group at a time runs into a memory stall while the other groups still have work to offer.

A warp that has been picked stays out of the selection until the pipeline reports that it has completed. The selection and its valid flag are combinational functions of the current inputs and the registered scheduler state.

Top module: `tlrr_warp_sched`

## Requirements
- R1: Warp w belongs to fetch group w / GROUP_SIZE, so groups hold consecutive IDs. A warp is eligible when its ready bit is 1, its stall bit is 0, and it is not busy.
- R2: A warp of a lower-ranked group is picked only when no warp of any higher-ranked group is eligible. This includes the case where the top group is not fully stalled but has no eligible warp.
- R3: Inside a group, the pick is the first eligible warp after the one most recently picked in that group, wrapping round. After reset the search of every group starts at its lowest warp.
- R4: When all stall bits of the top group are 1, the next cycle's top group is the following group ID (wrapping), and the old top group becomes the lowest rank.
- R5: Each retire pulse advances a counter. When a pulse brings the count to timeout_lim_i, the ranking rotates by one. The counter clears on every rotation, whatever caused it.
- R6: A picked warp is busy from the next cycle until the cycle after its done bit is 1. The same warp is never picked in two consecutive cycles.
- R7: When no warp is eligible, sel_valid_o is 0, sel_id_o is 0, and the round-robin positions of all groups are unchanged.
- R8: With GROUP_SIZE equal to NUM_WARPS, the picks follow plain round-robin over the eligible warps.
- R9: After reset, group 0 is top and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_i | input | NUM_WARPS | Warp has an instruction ready to fetch |
| stall_i | input | NUM_WARPS | Warp is waiting on a long-latency operation |
| done_i | input | NUM_WARPS | Warp's previous pick has left the pipeline |
| retire_i | input | 1 | One instruction retired this cycle |
| timeout_lim_i | input | CNT_W | Retire count that forces a group rotation |
| sel_valid_o | output | 1 | A warp is selected this cycle |
| sel_id_o | output | log2(NUM_WARPS) | Selected warp ID, 0 when not valid |

## Verification
The hardest state to reach is a top group with no eligible warp even though it is not fully stalled, while lower groups do have eligible warps. The stimulus reaches it by keeping every warp of the top group busy, holding back their done bits, so that the next group must be served without a rotation. The stimulus then fully stalls the top group while another group still has busy warps. This shows that the ranking moves while the selection first falls through to the one remaining eligible warp. Timeout rotation is driven with ready held low, so that only retire pulses act on the counter before a single probing cycle reveals which group is on top.

// File: rtl/tlrr_pkg.sv
package tlrr_pkg;
    // width of an index over n items, never zero
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tlrr_rr_pick.sv
module tlrr_rr_pick #(
    parameter int GS    = 4,
    parameter int IDX_W = 2
) (
    input  logic [GS-1:0]    req_i,
    input  logic [IDX_W-1:0] last_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    logic found;

    // scan starting one past the last served member, wrapping round
    always_comb begin
        found = 1'b0;
        idx_o = '0;
        for (int k = 1; k <= GS; k++) begin
            if (!found && req_i[(int'(last_i) + k) % GS]) begin
                found = 1'b1;
                idx_o = IDX_W'((int'(last_i) + k) % GS);
            end
        end
        any_o = found;
    end
endmodule

// File: rtl/tlrr_grp_rank.sv
module tlrr_grp_rank #(
    parameter int NG    = 2,
    parameter int GRP_W = 1
) (
    input  logic [NG-1:0]    any_i,
    input  logic [GRP_W-1:0] top_i,
    output logic             win_o,
    output logic [GRP_W-1:0] grp_o
);
    logic found;

    // rank order: top, top+1, ... wrapping
    always_comb begin
        found = 1'b0;
        grp_o = '0;
        for (int k = 0; k < NG; k++) begin
            if (!found && any_i[(int'(top_i) + k) % NG]) begin
                found = 1'b1;
                grp_o = GRP_W'((int'(top_i) + k) % NG);
            end
        end
        win_o = found;
    end
endmodule

// File: rtl/tlrr_warp_sched.sv
module tlrr_warp_sched #(
    parameter int NUM_WARPS  = 8,
    parameter int GROUP_SIZE = 4,
    parameter int CNT_W      = 16,
    localparam int NG    = NUM_WARPS / GROUP_SIZE,
    localparam int GRP_W = tlrr_pkg::idx_bits(NG),
    localparam int IDX_W = tlrr_pkg::idx_bits(GROUP_SIZE),
    localparam int ID_W  = tlrr_pkg::idx_bits(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] ready_i,
    input  logic [NUM_WARPS-1:0] stall_i,
    input  logic [NUM_WARPS-1:0] done_i,
    input  logic                 retire_i,
    input  logic [CNT_W-1:0]     timeout_lim_i,
    output logic                 sel_valid_o,
    output logic [ID_W-1:0]      sel_id_o
);
    typedef struct packed {
        logic [GRP_W-1:0]           top;
        logic [NG-1:0][IDX_W-1:0]   ptr;
        logic [NUM_WARPS-1:0]       busy;
        logic [CNT_W-1:0]           cnt;
    } state_t;

    state_t st_d, st_q, st_rst;

    logic [NUM_WARPS-1:0]     elig;
    logic [NG-1:0]            g_any;
    logic [NG-1:0][IDX_W-1:0] g_idx;
    logic                     win_v;
    logic [GRP_W-1:0]         win_g;
    logic                     top_stalled;
    logic                     tmo;
    logic                     rotate;
    logic [CNT_W:0]           cnt_inc;

    assign elig = ready_i & ~stall_i & ~st_q.busy;

    for (genvar g = 0; g < NG; g++) begin : gen_grp
        tlrr_rr_pick #(.GS(GROUP_SIZE), .IDX_W(IDX_W)) u_pick (
            .req_i  (elig[g*GROUP_SIZE +: GROUP_SIZE]),
            .last_i (st_q.ptr[g]),
            .any_o  (g_any[g]),
            .idx_o  (g_idx[g])
        );
    end

    tlrr_grp_rank #(.NG(NG), .GRP_W(GRP_W)) u_rank (
        .any_i (g_any),
        .top_i (st_q.top),
        .win_o (win_v),
        .grp_o (win_g)
    );

    always_comb begin
        st_rst      = '0;
        for (int g = 0; g < NG; g++) st_rst.ptr[g] = IDX_W'(GROUP_SIZE - 1);

        sel_valid_o = win_v;
        sel_id_o    = win_v ? ID_W'(int'(win_g) * GROUP_SIZE + int'(g_idx[win_g])) : '0;

        top_stalled = &stall_i[int'(st_q.top) * GROUP_SIZE +: GROUP_SIZE];
        cnt_inc     = {1'b0, st_q.cnt} + (CNT_W+1)'(1);
        tmo         = retire_i && (cnt_inc >= {1'b0, timeout_lim_i});
        rotate      = top_stalled || tmo;

        st_d = st_q;
        if (rotate) begin
            st_d.top = (int'(st_q.top) == NG - 1) ? '0 : st_q.top + GRP_W'(1);
            st_d.cnt = '0;
        end else if (retire_i) begin
            st_d.cnt = cnt_inc[CNT_W-1:0];
        end
        st_d.busy = st_q.busy & ~done_i;
        if (win_v) begin
            st_d.ptr[win_g]     = g_idx[win_g];
            st_d.busy[sel_id_o] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    // R1
    sel_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |-> (ready_i[sel_id_o] && !stall_i[sel_id_o]));

    // R4
    rot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.top) |->
            (int'(st_q.top) == (int'($past(st_q.top)) + 1) % NG));

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.top) |-> (st_q.cnt == '0));

    // R6
    no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |=> !(sel_valid_o && sel_id_o == $past(sel_id_o)));

    // R7
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ready_i & ~stall_i) == '0) |-> (!sel_valid_o && sel_id_o == '0));

    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid_o |=> $stable(st_q.ptr));
endmodule

// File: tb/test_tlrr_warp_sched.sv
module test_tlrr_warp_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ready = '0, stall = '0, done = '0;
    logic       retire = 1'b0;
    logic [15:0] lim = 16'd100;
    logic       sv;
    logic [2:0] sid;

    logic [7:0] f_ready = '0, f_stall = '0, f_done = '0;
    logic       f_sv;
    logic [2:0] f_sid;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tlrr_warp_sched #(.NUM_WARPS(8), .GROUP_SIZE(4), .CNT_W(16)) i_tlrr_warp_sched (
        .clk(clk), .rst_n(rst_n), .ready_i(ready), .stall_i(stall), .done_i(done),
        .retire_i(retire), .timeout_lim_i(lim), .sel_valid_o(sv), .sel_id_o(sid));

    tlrr_warp_sched #(.NUM_WARPS(8), .GROUP_SIZE(8), .CNT_W(16)) i_tlrr_warp_sched_flat (
        .clk(clk), .rst_n(rst_n), .ready_i(f_ready), .stall_i(f_stall), .done_i(f_done),
        .retire_i(1'b0), .timeout_lim_i(16'd100), .sel_valid_o(f_sv), .sel_id_o(f_sid));

    // {ready, stall, done, exp_valid, exp_id}
    localparam logic [27:0] VEC [0:16] = '{
        {8'hFF, 8'h00, 8'h00, 1'b1, 3'd0},  // R3 R9 first pick
        {8'hFF, 8'h00, 8'h00, 1'b1, 3'd1},  // R3
        {8'hFF, 8'h00, 8'h01, 1'b1, 3'd2},  // R6
        {8'hFF, 8'h00, 8'h00, 1'b1, 3'd3},  // R3
        {8'hFF, 8'h00, 8'h00, 1'b1, 3'd0},  // R6 freed warp
        {8'hFF, 8'h00, 8'h00, 1'b1, 3'd4},  // R2 top busy, not stalled
        {8'hFF, 8'h00, 8'h0F, 1'b1, 3'd5},  // R6 done takes a cycle
        {8'hFF, 8'h00, 8'h00, 1'b1, 3'd1},  // R2 top group back
        {8'hFF, 8'h0F, 8'h00, 1'b1, 3'd6},  // R4 group 0 stalled
        {8'hFF, 8'h0F, 8'h00, 1'b1, 3'd7},  // R4 group 1 now top
        {8'hFF, 8'h0F, 8'hF0, 1'b0, 3'd0},  // R7 nothing eligible
        {8'hFF, 8'h00, 8'h00, 1'b1, 3'd4},  // R2 group 1 outranks 0
        {8'hFF, 8'h00, 8'h00, 1'b1, 3'd5},  // R3
        {8'hFF, 8'hF0, 8'h00, 1'b1, 3'd2},  // R4 group 1 stalled
        {8'hFF, 8'hF0, 8'h00, 1'b1, 3'd3},  // R1 group 0 top again
        {8'h00, 8'h00, 8'hFF, 1'b0, 3'd0},  // R7 no ready
        {8'hFF, 8'h00, 8'h00, 1'b1, 3'd0}   // R7 pointer held
    };

    task automatic check(input string req, input logic av, input logic [2:0] aid,
                         input logic ev, input logic [2:0] eid);
        checks++;
        if (av !== ev || aid !== eid) begin
            errors++;
            $display("FAIL %s: valid/id = %0b/%0d, expected %0b/%0d", req, av, aid, ev, eid);
        end
    endtask

    task automatic drive(input logic [7:0] r, input logic [7:0] s, input logic [7:0] d,
                         input logic rt);
        @(negedge clk);
        ready = r; stall = s; done = d; retire = rt;
        #5;
    endtask

    task automatic fdrive(input logic [7:0] r, input logic [7:0] s, input logic [7:0] d);
        @(negedge clk);
        f_ready = r; f_stall = s; f_done = d;
        #5;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ready = '0; stall = '0; done = '0; retire = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R9 reset state, idle output
        drive(8'h00, 8'h00, 8'h00, 1'b0);
        check("R9 reset", sv, sid, 1'b0, 3'd0);

        do_reset();
        for (int i = 0; i < 17; i++) begin
            drive(VEC[i][27:20], VEC[i][19:12], VEC[i][11:4], 1'b0);
            check($sformatf("vector %0d", i), sv, sid, VEC[i][3], VEC[i][2:0]);
        end

        // R5 timeout rotation after lim retires, counter cleared on rotation
        do_reset();
        lim = 16'd3;
        drive(8'h00, 8'h00, 8'h00, 1'b1);
        drive(8'h00, 8'h00, 8'h00, 1'b1);
        drive(8'hFF, 8'h00, 8'h00, 1'b0);
        check("R5 no early rotation", sv, sid, 1'b1, 3'd0);
        drive(8'h00, 8'h00, 8'hFF, 1'b1);
        drive(8'hFF, 8'h00, 8'h00, 1'b0);
        check("R5 rotation at limit", sv, sid, 1'b1, 3'd4);
        drive(8'h00, 8'h00, 8'hFF, 1'b1);
        drive(8'h00, 8'h00, 8'h00, 1'b1);
        drive(8'hFF, 8'h00, 8'h00, 1'b0);
        check("R5 counter restarted", sv, sid, 1'b1, 3'd5);
        drive(8'h00, 8'h00, 8'hFF, 1'b0);

        // R8 single group acts as plain round-robin
        fdrive(8'hA5, 8'h00, 8'hFF);
        check("R8 rr 0", f_sv, f_sid, 1'b1, 3'd0);
        fdrive(8'hA5, 8'h00, 8'hFF);
        check("R8 rr 2", f_sv, f_sid, 1'b1, 3'd2);
        fdrive(8'hA5, 8'h00, 8'hFF);
        check("R8 rr 5", f_sv, f_sid, 1'b1, 3'd5);
        fdrive(8'hA5, 8'h00, 8'hFF);
        check("R8 rr 7", f_sv, f_sid, 1'b1, 3'd7);
        fdrive(8'hA5, 8'h00, 8'hFF);
        check("R8 rr wrap", f_sv, f_sid, 1'b1, 3'd0);
        fdrive(8'hFF, 8'hFF, 8'hFF);
        check("R8 all stalled", f_sv, f_sid, 1'b0, 3'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule